// File: doc/BRIEF.md
# Alarm Compare and Interrupt Status Unit

This unit sits beside the time-of-day counter of a real-time clock. It keeps two programmable alarm words, one for time of day and one for the calendar. It compares them against the running BCD time and calendar words, which the counter delivers as inputs. Each alarm field has its own enable bit, and a field takes part in the match only when its enable is set. The calendar alarm holds month and date only, with no year.

The alarm event joins four event pulses from the counter in a sticky status word: update acknowledge, new second, time event and calendar event. Software clears status bits by writing ones to a clear address. An interrupt mask is built up through a write-one-to-set address and a write-one-to-clear address, and can be read back. The single interrupt line is high whenever a status bit and its mask bit are both set. Access is a simple register port: a one-cycle write strobe with an address and data, and a read data bus that follows the address combinationally.

Top module: `rtc_alarm_irq`

## Requirements
- R1: Address 0x10 holds the time alarm. Seconds are BCD in bits 6:0 with enable bit 7, minutes are in bits 14:8 with enable bit 15, and hours are in bits 21:16 with enable bit 23. Other bits are not stored and read as zero, so an all-ones write reads back 0x00BFFFFF.
- R2: Address 0x14 holds the calendar alarm. Month is in bits 20:16 with enable bit 23, and date is in bits 29:24 with enable bit 31. Other bits are not stored, so an all-ones write reads back 0xBF9F0000.
- R3: The alarm condition is true when at least one field is enabled and every enabled field equals the same bits of the current time word (seconds, minutes, hours) or the current calendar word (month, date). Disabled fields and all other bits of the current words are ignored. With no field enabled the alarm never fires.
- R4: The alarm status bit is set in the cycle after the alarm condition becomes true. If the condition stays true, the bit is not set again after it has been cleared. It is set again only after the condition has gone false and then true again.
- R5: The status word reads at 0x18: bit 0 update acknowledge, bit 1 alarm, bit 2 second, bit 3 time event, bit 4 calendar event. Event input bits evtIn[0], [1], [2] and [3] set status bits 0, 2, 3 and 4 on the next clock. Status bits stay set until cleared.
- R6: Writing to 0x1c clears every status bit whose data bit is one. If an event for a bit arrives in the same cycle as the clear, the bit stays set.
- R7: Writing ones to 0x20 sets mask bits and writing ones to 0x24 clears mask bits. Zero data bits leave the mask unchanged. The mask reads at 0x28.
- R8: irq is high exactly when the bitwise AND of status and mask is nonzero.
- R9: After reset, both alarm words, the status word and the mask are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Register byte address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the register at addr |
| curTime | input | 32 | Current BCD time word from the counter |
| curCal | input | 32 | Current BCD calendar word from the counter |
| evtIn | input | 4 | Event pulses: update ack, second, time, calendar |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted status or mask bit shows up on irq in the same cycle, and on a readback of 0x18 or 0x28 at the next read. A wrong field compare or enable decode shows up one clock after the current words change, as a missing or spurious alarm bit. For that reason the bench sweeps every combination of field enables against every combination of mismatching fields. A wrong match-edge register shows up only when a match persists across a clear, so that case is driven on purpose. Every status pattern from the event inputs is crossed with every mask value to cover the interrupt combine.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int NSTAT = 5;
  localparam int NFLD  = 5;
  localparam int NEVT  = 4;

  localparam int OFF_TALM  = 'h10;
  localparam int OFF_CALM  = 'h14;
  localparam int OFF_STAT  = 'h18;
  localparam int OFF_SCLR  = 'h1c;
  localparam int OFF_MSET  = 'h20;
  localparam int OFF_MCLR  = 'h24;
  localparam int OFF_MASK  = 'h28;

  localparam logic [31:0] TALM_KEEP = 32'h00BF_FFFF;
  localparam logic [31:0] CALM_KEEP = 32'hBF9F_0000;

  typedef struct packed {
    logic wrTimeAlm;
    logic wrCalAlm;
    logic clrStat;
    logic setMask;
    logic clrMask;
  } almStrobe_t;

  typedef enum logic [2:0] {
    RD_ZERO, RD_TALM, RD_CALM, RD_STAT, RD_MASK
  } rdSel_t;

  // fields 0..2 come from the time word, 3..4 from the calendar word
  function automatic logic [31:0] fldMask(int f);
    case (f)
      0:       return 32'h0000_007F;
      1:       return 32'h0000_7F00;
      2:       return 32'h003F_0000;
      3:       return 32'h001F_0000;
      default: return 32'h3F00_0000;
    endcase
  endfunction

  function automatic int fldEnBit(int f);
    case (f)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      3:       return 23;
      default: return 31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alm_ctrl.sv
module rtc_alm_ctrl
  import rtc_alm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output almStrobe_t        strobe,
  output rdSel_t            rdSel
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      if (addr == ADDR_W'(OFF_TALM)) strobe.wrTimeAlm = 1'b1;
      if (addr == ADDR_W'(OFF_CALM)) strobe.wrCalAlm  = 1'b1;
      if (addr == ADDR_W'(OFF_SCLR)) strobe.clrStat   = 1'b1;
      if (addr == ADDR_W'(OFF_MSET)) strobe.setMask   = 1'b1;
      if (addr == ADDR_W'(OFF_MCLR)) strobe.clrMask   = 1'b1;
    end
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (addr == ADDR_W'(OFF_TALM)) rdSel = RD_TALM;
    if (addr == ADDR_W'(OFF_CALM)) rdSel = RD_CALM;
    if (addr == ADDR_W'(OFF_STAT)) rdSel = RD_STAT;
    if (addr == ADDR_W'(OFF_MASK)) rdSel = RD_MASK;
  end
endmodule

// File: rtl/rtc_alm_datapath.sv
module rtc_alm_datapath
  import rtc_alm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  almStrobe_t       strobe,
  input  rdSel_t           rdSel,
  input  logic [31:0]      wrData,
  input  logic [31:0]      curTime,
  input  logic [31:0]      curCal,
  input  logic [NEVT-1:0]  evtIn,
  output logic [31:0]      rdData,
  output logic [31:0]      timeAlm,
  output logic [31:0]      calAlm,
  output logic [NSTAT-1:0] statusVec,
  output logic [NSTAT-1:0] maskVec,
  output logic             irq
);
  logic [NFLD-1:0] fldEn;
  logic [NFLD-1:0] fldEq;
  logic            matchNow;
  logic            matchPrev;
  logic            almRise;
  logic [NSTAT-1:0] setBits;
  logic [NSTAT-1:0] clrBits;
  logic [NSTAT-1:0] mSet;
  logic [NSTAT-1:0] mClr;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    localparam logic [31:0] FM = fldMask(f);
    localparam int          EB = fldEnBit(f);
    logic [31:0] curW;
    logic [31:0] almW;
    if (f < 3) begin : g_time
      assign curW = curTime;
      assign almW = timeAlm;
    end else begin : g_cal
      assign curW = curCal;
      assign almW = calAlm;
    end
    assign fldEn[f] = almW[EB];
    assign fldEq[f] = ((curW ^ almW) & FM) == '0;
  end

  assign matchNow = (|fldEn) && (&(fldEq | ~fldEn));
  assign almRise  = matchNow && !matchPrev;

  assign setBits = {evtIn[3:1], almRise, evtIn[0]};
  assign clrBits = strobe.clrStat ? wrData[NSTAT-1:0] : '0;
  assign mSet    = strobe.setMask ? wrData[NSTAT-1:0] : '0;
  assign mClr    = strobe.clrMask ? wrData[NSTAT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeAlm   <= '0;
      calAlm    <= '0;
      statusVec <= '0;
      maskVec   <= '0;
      matchPrev <= 1'b0;
    end else begin
      if (strobe.wrTimeAlm) timeAlm <= wrData & TALM_KEEP;
      if (strobe.wrCalAlm)  calAlm  <= wrData & CALM_KEEP;
      statusVec <= (statusVec & ~clrBits) | setBits;
      maskVec   <= (maskVec | mSet) & ~mClr;
      matchPrev <= matchNow;
    end
  end

  assign irq = |(statusVec & maskVec);

  always_comb begin
    case (rdSel)
      RD_TALM: rdData = timeAlm;
      RD_CALM: rdData = calAlm;
      RD_STAT: rdData = {{(32-NSTAT){1'b0}}, statusVec};
      RD_MASK: rdData = {{(32-NSTAT){1'b0}}, maskVec};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [31:0]       curTime,
  input  logic [31:0]       curCal,
  input  logic [NEVT-1:0]   evtIn,
  output logic              irq
);
  almStrobe_t       strobe;
  rdSel_t           rdSel;
  logic [31:0]      timeAlm;
  logic [31:0]      calAlm;
  logic [NSTAT-1:0] statusVec;
  logic [NSTAT-1:0] maskVec;

  rtc_alm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  rtc_alm_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wrData    (wrData),
    .curTime   (curTime),
    .curCal    (curCal),
    .evtIn     (evtIn),
    .rdData    (rdData),
    .timeAlm   (timeAlm),
    .calAlm    (calAlm),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .irq       (irq)
  );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk
  import rtc_alm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [NSTAT-1:0]  wrLow,
  input logic [NEVT-1:0]   evtIn,
  input logic [6:0]        curSec,
  input logic [6:0]        almSec,
  input logic [NFLD-1:0]   almEn,
  input logic [NSTAT-1:0]  statusVec,
  input logic [NSTAT-1:0]  maskVec,
  input logic              irq
);
  logic             isClr;
  logic             isMSet;
  logic             isMClr;
  logic [NSTAT-1:0] evtMap;

  assign isClr  = wrEn && (addr == ADDR_W'(OFF_SCLR));
  assign isMSet = wrEn && (addr == ADDR_W'(OFF_MSET));
  assign isMClr = wrEn && (addr == ADDR_W'(OFF_MCLR));
  assign evtMap = {evtIn[3:1], 1'b0, evtIn[0]};

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (maskVec != '0 && statusVec != '0));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !isClr |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  p_event_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    (evtMap != '0) |=> ((statusVec & $past(evtMap)) == $past(evtMap)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isClr && evtIn == '0) |=> ((statusVec & $past(wrLow) & 5'b11101) == '0));

  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isMSet && !isMClr) |=> ((maskVec & $past(wrLow)) == $past(wrLow)));

  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    isMClr |=> ((maskVec & $past(wrLow)) == '0));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!isMSet && !isMClr) |=> $stable(maskVec));

  p_alarm_enabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[1]) |-> ($past(almEn) != '0));

  p_alarm_sec_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusVec[1]) && $past(almEn[0])) |-> ($past(curSec) == $past(almSec)));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrLow     (wrData[4:0]),
  .evtIn     (evtIn),
  .curSec    (curTime[6:0]),
  .almSec    (timeAlm[6:0]),
  .almEn     ({calAlm[31], calAlm[23], timeAlm[23], timeAlm[15], timeAlm[7]}),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .irq       (irq)
);

// File: tb/rtc_alarm_irq_test.sv
module rtc_alarm_irq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] curTime = '0;
  logic [31:0] curCal = '0;
  logic [3:0]  evtIn = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rtc_alarm_irq #(.ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .curTime(curTime), .curCal(curCal), .evtIn(evtIn), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  // current words: bit k of mis picks the mismatching value of field k
  function automatic logic [31:0] timeOf(input logic [4:0] mis);
    logic [31:0] t;
    t = 32'h0040_0000;                          // bit 22 set, must be ignored
    t[6:0]   = mis[0] ? 7'h46 : 7'h45;
    t[14:8]  = mis[1] ? 7'h13 : 7'h12;
    t[21:16] = mis[2] ? 6'h22 : 6'h23;
    return t;
  endfunction

  function automatic logic [31:0] calOf(input logic [4:0] mis);
    logic [31:0] c;
    c = 32'h0040_2019;                          // weekday, year, century ignored
    c[20:16] = mis[3] ? 5'h10 : 5'h11;
    c[29:24] = mis[4] ? 6'h27 : 6'h28;
    return c;
  endfunction

  function automatic logic [31:0] almTimeOf(input logic [4:0] en);
    return 32'h0023_1245 | (32'(en[0]) << 7) | (32'(en[1]) << 15) | (32'(en[2]) << 23);
  endfunction

  function automatic logic [31:0] almCalOf(input logic [4:0] en);
    return 32'h2811_0000 | (32'(en[3]) << 23) | (32'(en[4]) << 31);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [4:0]  expStat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(8'h10, v); chk(v == 0, "R9 time alarm reset", v, 0);
    rd(8'h14, v); chk(v == 0, "R9 calendar alarm reset", v, 0);
    rd(8'h18, v); chk(v == 0, "R9 status reset", v, 0);
    rd(8'h28, v); chk(v == 0, "R9 mask reset", v, 0);
    chk(irq == 1'b0, "R9 irq reset", 32'(irq), 0);

    // R1 / R2 stored bits
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk(v == 32'h00BF_FFFF, "R1 time alarm readback", v, 32'h00BF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); chk(v == 32'hBF9F_0000, "R2 calendar alarm readback", v, 32'hBF9F_0000);
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, v); chk(v == (32'h1234_5678 & 32'h00BF_FFFF), "R1 pattern readback", v, 32'h1234_5678 & 32'h00BF_FFFF);
    wr(8'h14, 32'h0000_0000);
    wr(8'h10, 32'h0000_0000);

    // R3 sweep: every enable set against every mismatch set
    for (int e = 0; e < 32; e++) begin
      wr(8'h10, almTimeOf(5'(e)));
      wr(8'h14, almCalOf(5'(e)));
      for (int m = 0; m < 32; m++) begin
        @(negedge clk);
        curTime = timeOf(5'h1F); curCal = calOf(5'h1F);
        @(negedge clk);
        wr(8'h1c, 32'h2);
        curTime = timeOf(5'(m)); curCal = calOf(5'(m));
        @(negedge clk); @(negedge clk);
        rd(8'h18, v);
        expStat = {3'b000, ((e != 0) && ((e & m) == 0)), 1'b0};
        chk(v[1] == expStat[1], $sformatf("R3 alarm en=%0d mis=%0d", e, m), 32'(v[1]), 32'(expStat[1]));
      end
    end

    // R4 persistent match does not refire after clear
    wr(8'h10, almTimeOf(5'b00001));
    wr(8'h14, 32'h0);
    curTime = timeOf(5'h1F); curCal = calOf(5'h1F);
    @(negedge clk);
    wr(8'h1c, 32'h1F);
    curTime = timeOf(5'h00);
    @(negedge clk); @(negedge clk);
    rd(8'h18, v); chk(v == 32'h2, "R4 alarm set on match start", v, 32'h2);
    wr(8'h1c, 32'h2);
    repeat (4) @(negedge clk);
    rd(8'h18, v); chk(v == 32'h0, "R4 no refire while match persists", v, 32'h0);
    curTime = timeOf(5'h01);
    @(negedge clk);
    curTime = timeOf(5'h00);
    @(negedge clk); @(negedge clk);
    rd(8'h18, v); chk(v == 32'h2, "R4 refire after match re-entry", v, 32'h2);
    wr(8'h10, 32'h0);
    curTime = timeOf(5'h1F);
    wr(8'h1c, 32'h1F);

    // R6 event in the same cycle as a clear wins
    @(negedge clk); evtIn = 4'b0010;
    @(negedge clk); evtIn = 4'b0000;
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h1c; wrData = 32'h4; evtIn = 4'b0010;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evtIn = 4'b0000;
    rd(8'h18, v); chk(v == 32'h4, "R6 event beats clear", v, 32'h4);
    wr(8'h1c, 32'h4);
    rd(8'h18, v); chk(v == 32'h0, "R6 clear alone", v, 32'h0);

    // R5 / R7 / R8 sweep: every event pattern against every mask
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 32; m++) begin
        wr(8'h1c, 32'h1F);
        wr(8'h24, 32'h1F);
        wr(8'h20, 32'(m));
        evtIn = 4'(s);
        @(negedge clk);
        evtIn = 4'b0000;
        @(negedge clk);
        expStat = {4'(s) >> 1, 1'b0, s[0]};
        rd(8'h18, v); chk(v == 32'(expStat), $sformatf("R5 status s=%0d", s), v, 32'(expStat));
        rd(8'h28, v); chk(v == 32'(m), $sformatf("R7 mask m=%0d", m), v, 32'(m));
        chk(irq == |(expStat & 5'(m)), $sformatf("R8 irq s=%0d m=%0d", s, m), 32'(irq), 32'(|(expStat & 5'(m))));
      end
    end

    // R7 partial set / clear leave other bits
    wr(8'h24, 32'h1F);
    wr(8'h20, 32'h05);
    wr(8'h20, 32'h08);
    rd(8'h28, v); chk(v == 32'h0D, "R7 set accumulates", v, 32'h0D);
    wr(8'h24, 32'h04);
    rd(8'h28, v); chk(v == 32'h09, "R7 clear selected bit", v, 32'h09);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule